// File: doc/BRIEF.md
# DRAM Bank Activity Monitor

This block watches a stream of timestamped DRAM commands without influencing it. For every bank it keeps an open/closed bit and counts activates, reads, writes, precharges and single-bank refreshes, plus the number of cycles the bank has been open. For the rank as a whole it tracks the cycles spent with at least one bank open and the cycles spent with every bank closed. It also counts all-bank refreshes. Commands that break the bank-state rules raise a one-cycle warning pulse. Such a command is otherwise handled as the rules below describe.

The refresh timing values (refresh cycle time, precharge time, minimum row-active time) arrive as static inputs. The monitor only reads them to size the refresh windows it charges. It does not enforce them. The counters are meant to feed a later activity or energy estimate.

Top module: `dram_bank_monitor`

## Requirements
- R1: An activate (opcode 0) to a closed bank opens it, records the command time as the bank's open start, and adds one to that bank's activate count.
- R2: An activate to an open bank changes no state and raises the warning.
- R3: An activate that opens a bank while every bank is closed adds (time − rank close time) to the rank closed-cycle counter and records the time as the rank open start.
- R4: A precharge (opcode 3) to an open bank closes it, adds one to its precharge count and adds (time − bank open start) to its open-cycle counter. If that bank was the only open bank, the precharge also adds (time − rank open start) to the rank open-cycle counter and sets the rank close time to the command time.
- R5: A precharge to a closed bank, and a precharge-all (opcode 4) with no bank open, change no state and raise the warning.
- R6: A precharge-all closes every bank. It applies the per-bank precharge accounting of R4 to the banks that were open, and only to those. It applies the rank close accounting once.
- R7: A read (opcode 1) or write (opcode 2) adds one to that bank's read or write count whether the bank is open or closed. The command raises the warning only when the bank is closed.
- R8: An all-bank refresh (opcode 5) does all of the following:
  - adds one to the refresh count;
  - adds (time − rank close time) to the closed-cycle counter;
  - adds W = tRFC − tRP to the rank open-cycle counter and to every bank's open-cycle counter;
  - closes all banks;
  - sets the rank close time to time + W.
- R9: An all-bank refresh issued while any bank is open raises the warning and is still carried out as in R8.
- R10: A per-bank refresh (opcode 6) to a closed bank adds tRAS + tRP to that bank's open-cycle counter and one to its refresh count. To an open bank it changes no state and raises the warning.
- R11: A time difference or window that would be negative is taken as zero before it is added.
- R12: Every counter is 32 bits wide and stops at 2^32−1 instead of wrapping.
- R13: Results of a command are visible one cycle after its strobe. The warning is a single-cycle pulse in that same cycle. Opcode 7 changes no state and raises the warning. A cycle without a strobe changes nothing.
- R14: Reset closes all banks, clears every counter, sets the rank close time to zero and holds the warning low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode: 0 act, 1 read, 2 write, 3 precharge, 4 precharge-all, 5 all-bank refresh, 6 per-bank refresh, 7 reserved |
| cmd_bank | input | BANK_W | Target bank index |
| cmd_time | input | 32 | Command timestamp, nondecreasing |
| t_rfc | input | 32 | Refresh cycle time |
| t_rp | input | 32 | Precharge time |
| t_ras | input | 32 | Minimum row-active time |
| warn | output | 1 | One-cycle illegal-command pulse |
| bank_open | output | NUM_BANKS | Open bit per bank |
| act_cnt | output | NUM_BANKS*32 | Activate counts, bank b at bits [32b+31:32b] |
| rd_cnt | output | NUM_BANKS*32 | Read counts, same packing |
| wr_cnt | output | NUM_BANKS*32 | Write counts, same packing |
| pre_cnt | output | NUM_BANKS*32 | Precharge counts, same packing |
| refb_cnt | output | NUM_BANKS*32 | Per-bank refresh counts, same packing |
| bank_open_cyc | output | NUM_BANKS*32 | Per-bank open cycles, same packing |
| rank_open_cyc | output | 32 | Cycles with at least one bank open |
| rank_closed_cyc | output | 32 | Cycles with all banks closed |
| ref_cnt | output | 32 | All-bank refresh count |

## Verification
The assertions are checked on every clock cycle. They cover these state transitions:
- an activate to a closed bank opens it, and one to an open bank leaves the bitmap as it was and warns;
- a precharge to an open bank closes it;
- an all-bank refresh empties the bitmap;
- a cycle with no strobe leaves the state alone and keeps the warning low;
- the rank counters never decrease.

The arithmetic can only be shown by the bench's scenarios, which compare every output against a model after each command. That arithmetic covers the elapsed-time charges, the refresh windows, clamping of negative differences, the once-only rank accounting under precharge-all, and saturation.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int TIME_W = 32;
  localparam int CNT_W  = 32;

  typedef enum logic [2:0] {
    OP_ACT  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_PRE  = 3'd3,
    OP_PREA = 3'd4,
    OP_REF  = 3'd5,
    OP_REFB = 3'd6,
    OP_RSVD = 3'd7
  } dbm_op_e;

  // saturating accumulate
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  // difference clamped at zero
  function automatic logic [CNT_W-1:0] clamp_sub(input logic [TIME_W-1:0] a,
                                                  input logic [TIME_W-1:0] b);
    return (a >= b) ? CNT_W'(a - b) : '0;
  endfunction
endpackage

// File: rtl/dbm_decode.sv
module dbm_decode
  import dbm_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 3
) (
  input  logic          valid,
  input  logic [2:0]    op,
  input  logic [BW-1:0] bank,
  input  logic [NB-1:0] open_vec,
  output logic [NB-1:0] ev_act,
  output logic [NB-1:0] ev_rd,
  output logic [NB-1:0] ev_wr,
  output logic [NB-1:0] ev_pre,
  output logic [NB-1:0] ev_refb,
  output logic          ev_ref,
  output logic          rank_open_ev,
  output logic          rank_close_ev,
  output logic          warn_d
);
  logic [NB-1:0] sel;
  logic          bank_ok;
  logic          tgt_open;
  logic          any_open;

  always_comb begin
    bank_ok  = (int'(bank) < NB);
    sel      = bank_ok ? (NB'(1) << bank) : '0;
    tgt_open = |(open_vec & sel);
    any_open = |open_vec;
  end

  always_comb begin
    ev_act        = '0;
    ev_rd         = '0;
    ev_wr         = '0;
    ev_pre        = '0;
    ev_refb       = '0;
    ev_ref        = 1'b0;
    rank_open_ev  = 1'b0;
    rank_close_ev = 1'b0;
    warn_d        = 1'b0;
    if (valid) begin
      case (dbm_op_e'(op))
        OP_ACT: begin
          if (!bank_ok || tgt_open) warn_d = 1'b1;
          else begin
            ev_act       = sel;
            rank_open_ev = !any_open;
          end
        end
        OP_RD: begin
          ev_rd  = sel;
          warn_d = !tgt_open;
        end
        OP_WR: begin
          ev_wr  = sel;
          warn_d = !tgt_open;
        end
        OP_PRE: begin
          if (tgt_open) begin
            ev_pre        = sel;
            rank_close_ev = (open_vec == sel);
          end else warn_d = 1'b1;
        end
        OP_PREA: begin
          if (any_open) begin
            ev_pre        = open_vec;
            rank_close_ev = 1'b1;
          end else warn_d = 1'b1;
        end
        OP_REF: begin
          ev_ref = 1'b1;
          warn_d = any_open;
        end
        OP_REFB: begin
          if (!bank_ok || tgt_open) warn_d = 1'b1;
          else ev_refb = sel;
        end
        default: warn_d = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dbm_bank.sv
module dbm_bank
  import dbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic              ev_act,
  input  logic              ev_rd,
  input  logic              ev_wr,
  input  logic              ev_pre,
  input  logic              ev_refb,
  input  logic              ev_ref,
  input  logic [CNT_W-1:0]  ref_win,
  input  logic [CNT_W-1:0]  refb_win,
  output logic              is_open,
  output logic [CNT_W-1:0]  act_cnt,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic [CNT_W-1:0]  pre_cnt,
  output logic [CNT_W-1:0]  refb_cnt,
  output logic [CNT_W-1:0]  open_cyc
);
  logic              open_q, open_d;
  logic [TIME_W-1:0] start_q, start_d;
  logic [CNT_W-1:0]  act_q, act_d, rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0]  pre_q, pre_d, refb_q, refb_d, ocyc_q, ocyc_d;
  logic              upd;

  always_comb begin
    upd     = ev_act | ev_rd | ev_wr | ev_pre | ev_refb | ev_ref;
    open_d  = open_q;
    start_d = start_q;
    act_d   = act_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    pre_d   = pre_q;
    refb_d  = refb_q;
    ocyc_d  = ocyc_q;
    if (ev_act) begin
      open_d  = 1'b1;
      start_d = now;
      act_d   = sat_add(act_q, CNT_W'(1));
    end
    if (ev_rd) rd_d = sat_add(rd_q, CNT_W'(1));
    if (ev_wr) wr_d = sat_add(wr_q, CNT_W'(1));
    if (ev_pre) begin
      ocyc_d = sat_add(ocyc_q, clamp_sub(now, start_q));
      pre_d  = sat_add(pre_q, CNT_W'(1));
      open_d = 1'b0;
    end
    if (ev_refb) begin
      ocyc_d = sat_add(ocyc_q, refb_win);
      refb_d = sat_add(refb_q, CNT_W'(1));
    end
    if (ev_ref) begin
      ocyc_d = sat_add(ocyc_q, ref_win);
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      start_q <= '0;
      act_q   <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      pre_q   <= '0;
      refb_q  <= '0;
      ocyc_q  <= '0;
    end else if (upd) begin
      open_q  <= open_d;
      start_q <= start_d;
      act_q   <= act_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      pre_q   <= pre_d;
      refb_q  <= refb_d;
      ocyc_q  <= ocyc_d;
    end
  end

  // R12
  bank_ocyc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ocyc_q >= $past(ocyc_q));

  assign is_open  = open_q;
  assign act_cnt  = act_q;
  assign rd_cnt   = rd_q;
  assign wr_cnt   = wr_q;
  assign pre_cnt  = pre_q;
  assign refb_cnt = refb_q;
  assign open_cyc = ocyc_q;
endmodule

// File: rtl/dbm_rank.sv
module dbm_rank
  import dbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic              open_ev,
  input  logic              close_ev,
  input  logic              ref_ev,
  input  logic [CNT_W-1:0]  ref_win,
  output logic [CNT_W-1:0]  open_cyc,
  output logic [CNT_W-1:0]  closed_cyc,
  output logic [CNT_W-1:0]  ref_cnt
);
  logic [TIME_W-1:0] ostart_q, ostart_d, close_q, close_d;
  logic [CNT_W-1:0]  ocyc_q, ocyc_d, ccyc_q, ccyc_d, ref_q, ref_d;
  logic              upd;

  always_comb begin
    upd      = open_ev | close_ev | ref_ev;
    ostart_d = ostart_q;
    close_d  = close_q;
    ocyc_d   = ocyc_q;
    ccyc_d   = ccyc_q;
    ref_d    = ref_q;
    if (open_ev) begin
      ccyc_d   = sat_add(ccyc_q, clamp_sub(now, close_q));
      ostart_d = now;
    end
    if (close_ev) begin
      ocyc_d  = sat_add(ocyc_q, clamp_sub(now, ostart_q));
      close_d = now;
    end
    if (ref_ev) begin
      ccyc_d  = sat_add(ccyc_q, clamp_sub(now, close_q));
      ocyc_d  = sat_add(ocyc_q, ref_win);
      close_d = now + TIME_W'(ref_win);
      ref_d   = sat_add(ref_q, CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ostart_q <= '0;
      close_q  <= '0;
      ocyc_q   <= '0;
      ccyc_q   <= '0;
      ref_q    <= '0;
    end else if (upd) begin
      ostart_q <= ostart_d;
      close_q  <= close_d;
      ocyc_q   <= ocyc_d;
      ccyc_q   <= ccyc_d;
      ref_q    <= ref_d;
    end
  end

  // R12
  rank_open_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ocyc_q >= $past(ocyc_q));
  // R12
  rank_closed_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ccyc_q >= $past(ccyc_q));

  assign open_cyc   = ocyc_q;
  assign closed_cyc = ccyc_q;
  assign ref_cnt    = ref_q;
endmodule

// File: rtl/dram_bank_monitor.sv
module dram_bank_monitor
  import dbm_pkg::*;
#(
  parameter  int NUM_BANKS = 8,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int VW        = NUM_BANKS * CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [TIME_W-1:0]    cmd_time,
  input  logic [CNT_W-1:0]     t_rfc,
  input  logic [CNT_W-1:0]     t_rp,
  input  logic [CNT_W-1:0]     t_ras,
  output logic                 warn,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [VW-1:0]        act_cnt,
  output logic [VW-1:0]        rd_cnt,
  output logic [VW-1:0]        wr_cnt,
  output logic [VW-1:0]        pre_cnt,
  output logic [VW-1:0]        refb_cnt,
  output logic [VW-1:0]        bank_open_cyc,
  output logic [CNT_W-1:0]     rank_open_cyc,
  output logic [CNT_W-1:0]     rank_closed_cyc,
  output logic [CNT_W-1:0]     ref_cnt
);
  logic [NUM_BANKS-1:0] ev_act, ev_rd, ev_wr, ev_pre, ev_refb;
  logic                 ev_ref, rank_open_ev, rank_close_ev, warn_d, warn_q;
  logic [CNT_W-1:0]     ref_win, refb_win;

  always_comb begin
    ref_win  = clamp_sub(t_rfc, t_rp);
    refb_win = sat_add(t_ras, t_rp);
  end

  dbm_decode #(.NB(NUM_BANKS), .BW(BANK_W)) i_decode (
    .valid         (cmd_valid),
    .op            (cmd_op),
    .bank          (cmd_bank),
    .open_vec      (bank_open),
    .ev_act        (ev_act),
    .ev_rd         (ev_rd),
    .ev_wr         (ev_wr),
    .ev_pre        (ev_pre),
    .ev_refb       (ev_refb),
    .ev_ref        (ev_ref),
    .rank_open_ev  (rank_open_ev),
    .rank_close_ev (rank_close_ev),
    .warn_d        (warn_d)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbm_bank i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .now      (cmd_time),
      .ev_act   (ev_act[b]),
      .ev_rd    (ev_rd[b]),
      .ev_wr    (ev_wr[b]),
      .ev_pre   (ev_pre[b]),
      .ev_refb  (ev_refb[b]),
      .ev_ref   (ev_ref),
      .ref_win  (ref_win),
      .refb_win (refb_win),
      .is_open  (bank_open[b]),
      .act_cnt  (act_cnt[b*CNT_W +: CNT_W]),
      .rd_cnt   (rd_cnt[b*CNT_W +: CNT_W]),
      .wr_cnt   (wr_cnt[b*CNT_W +: CNT_W]),
      .pre_cnt  (pre_cnt[b*CNT_W +: CNT_W]),
      .refb_cnt (refb_cnt[b*CNT_W +: CNT_W]),
      .open_cyc (bank_open_cyc[b*CNT_W +: CNT_W])
    );
  end

  dbm_rank i_rank (
    .clk        (clk),
    .rst_n      (rst_n),
    .now        (cmd_time),
    .open_ev    (rank_open_ev),
    .close_ev   (rank_close_ev),
    .ref_ev     (ev_ref),
    .ref_win    (ref_win),
    .open_cyc   (rank_open_cyc),
    .closed_cyc (rank_closed_cyc),
    .ref_cnt    (ref_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= warn_d;
  end
  assign warn = warn_q;

  // R1
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_ACT && !bank_open[cmd_bank] |=> bank_open[$past(cmd_bank)]);
  // R2
  act_again_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_ACT && bank_open[cmd_bank] |=> warn && $stable(bank_open));
  // R4
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PRE && bank_open[cmd_bank] |=> !bank_open[$past(cmd_bank)]);
  // R8
  ref_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_REF |=> bank_open == '0);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !warn && $stable(bank_open));
endmodule

// File: tb/test_dram_bank_monitor.sv
module test_dram_bank_monitor;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NB = 8;
  localparam int BW = 3;
  localparam longint MAXC = 64'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [31:0]   cmd_time, t_rfc, t_rp, t_ras;
  logic          warn;
  logic [NB-1:0] bank_open;
  logic [NB*32-1:0] act_cnt, rd_cnt, wr_cnt, pre_cnt, refb_cnt, bank_open_cyc;
  logic [31:0]   rank_open_cyc, rank_closed_cyc, ref_cnt;

  always #2.5 clk = ~clk;

  dram_bank_monitor #(.NUM_BANKS(NB)) i_dram_bank_monitor (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_time(cmd_time), .t_rfc(t_rfc), .t_rp(t_rp),
    .t_ras(t_ras), .warn(warn), .bank_open(bank_open), .act_cnt(act_cnt),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .pre_cnt(pre_cnt), .refb_cnt(refb_cnt),
    .bank_open_cyc(bank_open_cyc), .rank_open_cyc(rank_open_cyc),
    .rank_closed_cyc(rank_closed_cyc), .ref_cnt(ref_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state
  bit          m_open [NB];
  longint      m_start[NB], m_act[NB], m_rd[NB], m_wr[NB], m_pre[NB], m_refb[NB], m_ocyc[NB];
  longint      m_rstart, m_rclose, m_rop, m_rcl, m_ref;
  bit          m_warn;

  function automatic longint sat(longint a, longint b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  function automatic longint clampd(longint a, longint b);
    return (a >= b) ? a - b : 0;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic mdl_reset();
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_start[b] = 0; m_act[b] = 0; m_rd[b] = 0; m_wr[b] = 0;
      m_pre[b] = 0; m_refb[b] = 0; m_ocyc[b] = 0;
    end
    m_rstart = 0; m_rclose = 0; m_rop = 0; m_rcl = 0; m_ref = 0; m_warn = 0;
  endtask

  task automatic mdl_apply(int op, int b, longint t);
    int nopen = 0;
    longint w;
    for (int i = 0; i < NB; i++) nopen += int'(m_open[i]);
    m_warn = 0;
    case (op)
      0: if (m_open[b]) m_warn = 1;
         else begin
           if (nopen == 0) begin m_rcl = sat(m_rcl, clampd(t, m_rclose)); m_rstart = t; end
           m_open[b] = 1; m_start[b] = t; m_act[b] = sat(m_act[b], 1);
         end
      1: begin m_rd[b] = sat(m_rd[b], 1); m_warn = !m_open[b]; end
      2: begin m_wr[b] = sat(m_wr[b], 1); m_warn = !m_open[b]; end
      3: if (m_open[b]) begin
           m_ocyc[b] = sat(m_ocyc[b], clampd(t, m_start[b]));
           m_pre[b] = sat(m_pre[b], 1);
           if (nopen == 1) begin m_rop = sat(m_rop, clampd(t, m_rstart)); m_rclose = t; end
           m_open[b] = 0;
         end else m_warn = 1;
      4: if (nopen > 0) begin
           for (int i = 0; i < NB; i++) if (m_open[i]) begin
             m_ocyc[i] = sat(m_ocyc[i], clampd(t, m_start[i]));
             m_pre[i] = sat(m_pre[i], 1);
             m_open[i] = 0;
           end
           m_rop = sat(m_rop, clampd(t, m_rstart)); m_rclose = t;
         end else m_warn = 1;
      5: begin
           m_warn = (nopen > 0);
           w = clampd(t_rfc, t_rp);
           m_rcl = sat(m_rcl, clampd(t, m_rclose));
           m_rop = sat(m_rop, w);
           for (int i = 0; i < NB; i++) begin m_ocyc[i] = sat(m_ocyc[i], w); m_open[i] = 0; end
           m_rclose = (t + w) & MAXC;
           m_ref = sat(m_ref, 1);
         end
      6: if (!m_open[b]) begin
           m_ocyc[b] = sat(m_ocyc[b], sat(t_ras, t_rp));
           m_refb[b] = sat(m_refb[b], 1);
         end else m_warn = 1;
      default: m_warn = 1;
    endcase
  endtask

  task automatic compare(string tag);
    chk(warn == m_warn, tag, "warn", warn, m_warn);
    for (int b = 0; b < NB; b++) begin
      chk(bank_open[b] == m_open[b], tag, $sformatf("open[%0d]", b), bank_open[b], m_open[b]);
      chk(act_cnt[b*32 +: 32] == m_act[b], tag, $sformatf("act[%0d]", b), act_cnt[b*32 +: 32], m_act[b]);
      chk(rd_cnt[b*32 +: 32] == m_rd[b], tag, $sformatf("rd[%0d]", b), rd_cnt[b*32 +: 32], m_rd[b]);
      chk(wr_cnt[b*32 +: 32] == m_wr[b], tag, $sformatf("wr[%0d]", b), wr_cnt[b*32 +: 32], m_wr[b]);
      chk(pre_cnt[b*32 +: 32] == m_pre[b], tag, $sformatf("pre[%0d]", b), pre_cnt[b*32 +: 32], m_pre[b]);
      chk(refb_cnt[b*32 +: 32] == m_refb[b], tag, $sformatf("refb[%0d]", b), refb_cnt[b*32 +: 32], m_refb[b]);
      chk(bank_open_cyc[b*32 +: 32] == m_ocyc[b], tag, $sformatf("ocyc[%0d]", b), bank_open_cyc[b*32 +: 32], m_ocyc[b]);
    end
    chk(rank_open_cyc == m_rop, tag, "rank_open", rank_open_cyc, m_rop);
    chk(rank_closed_cyc == m_rcl, tag, "rank_closed", rank_closed_cyc, m_rcl);
    chk(ref_cnt == m_ref, tag, "ref_cnt", ref_cnt, m_ref);
  endtask

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1, 2: return "R7";
      3: return "R4";
      4: return "R6";
      5: return "R8";
      6: return "R10";
      default: return "R13";
    endcase
  endfunction

  // drive one strobe at a falling edge, check one cycle later
  task automatic issue(int op, int b, longint t, string tag);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_bank = BW'(b); cmd_time = 32'(t);
    @(negedge clk);
    cmd_valid = 1'b0;
    mdl_apply(op, b, t);
    compare(tag);
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    m_warn = 0;
    compare(tag);
  endtask

  initial begin
    longint t;
    int r, op;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_bank = '0; cmd_time = '0;
    t_rfc = 32'd40; t_rp = 32'd6; t_ras = 32'd14;
    mdl_reset();
    repeat (3) @(negedge clk);
    compare("R14");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R14");

    // directed
    issue(0, 2, 50, "R3");    // first open: closed += 50
    issue(0, 2, 55, "R2");    // already open
    issue(0, 5, 60, "R1");
    issue(1, 3, 61, "R7");    // read closed bank: counted, warns
    issue(2, 5, 62, "R7");
    issue(3, 2, 70, "R4");    // not last open bank
    issue(3, 2, 71, "R5");    // closed precharge
    issue(6, 5, 72, "R10");   // refb on open bank
    issue(6, 1, 73, "R10");   // refb on closed bank
    issue(0, 1, 74, "R6");
    issue(4, 0, 90, "R6");    // closes 1 and 5, rank close once
    issue(4, 0, 91, "R5");    // nothing open
    idle_check("R13");
    issue(7, 4, 92, "R13");   // reserved
    idle_check("R13");
    issue(0, 0, 100, "R9");
    issue(5, 0, 110, "R9");   // refresh with open bank
    issue(5, 0, 120, "R8");   // before close time: clamped
    issue(0, 6, 200, "R3");
    issue(3, 6, 150, "R11");  // time earlier than open start
    t_rfc = 32'd3; t_rp = 32'd8;
    issue(5, 0, 210, "R11");  // negative window
    t_rfc = 32'd40; t_rp = 32'd6;

    // random
    t = 300;
    for (int i = 0; i < 600; i++) begin
      r = int'($urandom % 10);
      case (r)
        0, 1, 2: op = 0;
        3: op = 1;
        4: op = 2;
        5, 6: op = 3;
        7: op = 4;
        8: op = ($urandom % 2 == 0) ? 5 : 6;
        default: op = ($urandom % 4 == 0) ? 7 : 6;
      endcase
      t += longint'($urandom % 16);
      issue(op, int'($urandom % NB), t, tag_of(op));
      if ($urandom % 5 == 0) idle_check("R13");
    end

    // saturation
    t_ras = 32'h7FFF_FFFF; t_rp = 32'h7FFF_FFFF;
    issue(4, 0, t + 1, "R12");
    issue(6, 3, t + 2, "R12");
    issue(6, 3, t + 3, "R12");
    issue(6, 3, t + 4, "R12");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R13 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule